// File: doc/BRIEF.md
# Missing-Layer Majority Chain with Road Flag

This block decides whether a stored track pattern has matched on enough detector layers to count as a road candidate. It does not add up per-layer match bits. A three-bit thermometer code starts at the all-ones value and passes through one selector stage per layer. A stage whose layer matched leaves the code as it is. A stage whose layer missed moves the code one level down. The lowest level holds. The code that leaves the last stage gives the number of missing layers: none, one, two, or three-or-more.

A two-bit tolerance input sets how many missing layers are still accepted. It picks which bit of the final code raises the road flag. The final code and the road flag are both registered once, so results appear one clock after the match bits and the tolerance are presented. A new pattern can be applied on every cycle.

Top module: `road_majority_chain`

## Requirements
- R1: While `rstN` is low, `missCode` is 3'b000 and `roadFlag` is 0, whatever the inputs are.
- R2: When every bit of `matchBits` is 1, `missCode` is 3'b111 on the next clock.
- R3: When exactly one bit of `matchBits` is 0, `missCode` is 3'b011 on the next clock. This holds whichever layer missed.
- R4: When exactly two bits of `matchBits` are 0, `missCode` is 3'b001 on the next clock. This holds whichever layers missed.
- R5: When three or more bits of `matchBits` are 0, `missCode` is 3'b000 on the next clock. The code never leaves the set {111, 011, 001, 000}.
- R6: With `tolerance` = 0, `roadFlag` is 1 only for a perfect match (`missCode` = 111).
- R7: With `tolerance` = 1, `roadFlag` is 1 when at most one layer is missing (`missCode` bit 1 set).
- R8: With `tolerance` = 2, and also with 3, which acts as 2, `roadFlag` is 1 when at most two layers are missing (`missCode` bit 0 set). The flag is never raised with three or more missing.
- R9: Latency is one clock, with no stall. Patterns presented on consecutive cycles each give their own result on the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| matchBits | input | NUM_LAYERS | Per-layer match bits; bit i is 1 when layer i matched |
| tolerance | input | 2 | Missing layers accepted (0, 1, 2; 3 acts as 2) |
| missCode | output | 3 | Registered thermometer code of missing layers |
| roadFlag | output | 1 | Registered road decision |

## Verification
The hardest case to reach is a miss that arrives after the code has already saturated. It must leave the code at 000 and must not wrap or corrupt it. This only happens when three or more layers miss and at least one more miss falls later in the chain. The bench therefore sweeps every one of the 64 match patterns under all four tolerance settings, which includes the all-miss pattern and every placement of one and two misses. Back-to-back patterns with no idle cycles check that each result belongs to the pattern of the cycle before.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] therm_t;

  localparam therm_t CODE_NONE_MISSING = 3'b111;
  localparam therm_t CODE_ONE_MISSING  = 3'b011;
  localparam therm_t CODE_TWO_MISSING  = 3'b001;
  localparam therm_t CODE_MANY_MISSING = 3'b000;

  // one-hot strobes from control to datapath: which code bit drives the flag
  typedef struct packed {
    logic needPerfect;
    logic allowOne;
    logic allowTwo;
  } tolSel_t;

  function automatic logic isLegal(therm_t c);
    return (c == CODE_NONE_MISSING) || (c == CODE_ONE_MISSING) ||
           (c == CODE_TWO_MISSING)  || (c == CODE_MANY_MISSING);
  endfunction
endpackage

// File: rtl/rmc_stage.sv
module rmc_stage
  import rmc_pkg::*;
(
  input  therm_t codeIn,
  input  logic   layerHit,
  output therm_t codeOut
);
  therm_t cleanCode;

  // anything outside the thermometer set collapses to the saturated value
  always_comb begin
    cleanCode = isLegal(codeIn) ? codeIn : CODE_MANY_MISSING;
    codeOut   = layerHit ? cleanCode : {1'b0, cleanCode[CODE_W-1:1]};
  end

  always_comb begin
    assert_stage_legal_R5: assert (isLegal(codeOut))
      else $error("stage produced non-thermometer code %b", codeOut);
  end
endmodule

// File: rtl/rmc_control.sv
module rmc_control
  import rmc_pkg::*;
(
  input  logic [1:0] tolerance,
  output tolSel_t    sel
);
  always_comb begin
    sel = '0;
    unique case (tolerance)
      2'd0:    sel.needPerfect = 1'b1;
      2'd1:    sel.allowOne    = 1'b1;
      default: sel.allowTwo    = 1'b1;
    endcase
  end
endmodule

// File: rtl/rmc_datapath.sv
module rmc_datapath
  import rmc_pkg::*;
#(
  parameter int NUM_LAYERS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LAYERS-1:0] matchBits,
  input  tolSel_t               sel,
  output therm_t                codeQ,
  output logic                  flagQ
);
  localparam int LAST = NUM_LAYERS;

  therm_t codeChain [LAST+1];
  logic   flagNext;

  assign codeChain[0] = CODE_NONE_MISSING;

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : gStage
    rmc_stage uStage (
      .codeIn  (codeChain[i]),
      .layerHit(matchBits[i]),
      .codeOut (codeChain[i+1])
    );
  end

  always_comb begin
    flagNext = (sel.needPerfect & codeChain[LAST][2]) |
               (sel.allowOne    & codeChain[LAST][1]) |
               (sel.allowTwo    & codeChain[LAST][0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= CODE_MANY_MISSING;
      flagQ <= 1'b0;
    end else begin
      codeQ <= codeChain[LAST];
      flagQ <= flagNext;
    end
  end

  assert_all_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (&matchBits) |=> (codeQ == CODE_NONE_MISSING));

  assert_one_miss_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~matchBits) == 1) |=> (codeQ == CODE_ONE_MISSING));

  assert_two_miss_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~matchBits) == 2) |=> (codeQ == CODE_TWO_MISSING));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~matchBits) >= 3) |=> (codeQ == CODE_MANY_MISSING));

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(sel) == 1);
endmodule

// File: rtl/road_majority_chain.sv
module road_majority_chain
  import rmc_pkg::*;
#(
  parameter int NUM_LAYERS = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LAYERS-1:0] matchBits,
  input  logic [1:0]            tolerance,
  output logic [2:0]            missCode,
  output logic                  roadFlag
);
  tolSel_t sel;
  therm_t  codeQ;
  logic    flagQ;

  rmc_control uControl (
    .tolerance(tolerance),
    .sel      (sel)
  );

  rmc_datapath #(.NUM_LAYERS(NUM_LAYERS)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .matchBits(matchBits),
    .sel      (sel),
    .codeQ    (codeQ),
    .flagQ    (flagQ)
  );

  assign missCode = codeQ;
  assign roadFlag = flagQ;

  assert_strict_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (roadFlag && $past(tolerance) == 2'd0) |-> (missCode == CODE_NONE_MISSING));

  assert_one_tol_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (roadFlag && $past(tolerance) == 2'd1) |-> missCode[1]);

  assert_never_flag_many_R8: assert property (@(posedge clk) disable iff (!rstN)
    roadFlag |-> (missCode != CODE_MANY_MISSING));
endmodule

// File: tb/tb_road_majority_chain.sv
module tb_road_majority_chain;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] matchBits = '1;
  logic [1:0]   tolerance = 2'd0;
  logic [2:0]   missCode;
  logic         roadFlag;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  road_majority_chain #(.NUM_LAYERS(N)) dut (
    .clk(clk), .rstN(rstN), .matchBits(matchBits), .tolerance(tolerance),
    .missCode(missCode), .roadFlag(roadFlag)
  );

  function automatic logic [2:0] expCode(logic [N-1:0] m);
    int miss = N - $countones(m);
    case (miss)
      0:       return 3'b111;
      1:       return 3'b011;
      2:       return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic expFlag(logic [N-1:0] m, logic [1:0] t);
    int miss = N - $countones(m);
    int allow = (t == 2'd3) ? 2 : int'(t);
    return miss <= allow;
  endfunction

  task automatic checkOut(string req, logic [2:0] eCode, logic eFlag);
    checks++;
    if (missCode !== eCode || roadFlag !== eFlag) begin
      errors++;
      $display("FAIL %s: code=%b flag=%b expected code=%b flag=%b",
               req, missCode, roadFlag, eCode, eFlag);
    end
  endtask

  // drive at a falling edge, check at the next falling edge (one register)
  task automatic applyCheck(string req, logic [N-1:0] m, logic [1:0] t);
    @(negedge clk);
    matchBits = m;
    tolerance = t;
    @(negedge clk);
    checkOut(req, expCode(m), expFlag(m, t));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    matchBits = '1;
    tolerance = 2'd2;
    repeat (3) @(negedge clk);
    checkOut("R1", 3'b000, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic testPerfect();
    applyCheck("R2", '1, 2'd0);
  endtask

  task automatic testSingleMiss();
    for (int i = 0; i < N; i++) applyCheck("R3", ~(N'(1) << i), 2'd1);
  endtask

  task automatic testDoubleMiss();
    applyCheck("R4", ~N'(6'b000011), 2'd2);
    applyCheck("R4", ~N'(6'b100001), 2'd1);
  endtask

  task automatic testSaturation();
    applyCheck("R5", '0, 2'd2);
    applyCheck("R5", ~N'(6'b010101), 2'd3);
  endtask

  task automatic testToleranceSweep();
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < (1 << N); p++) begin
        string req = (t == 0) ? "R6" : (t == 1) ? "R7" : "R8";
        applyCheck(req, N'(p), 2'(t));
      end
    end
  endtask

  task automatic testBackToBack();
    logic [N-1:0] seq [4];
    seq[0] = '1; seq[1] = ~N'(6'b001000); seq[2] = '0; seq[3] = ~N'(6'b000110);
    @(negedge clk);
    matchBits = seq[0];
    tolerance = 2'd1;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      checkOut("R9", expCode(seq[k-1]), expFlag(seq[k-1], 2'd1));
      matchBits = seq[k];
    end
    @(negedge clk);
    checkOut("R9", expCode(seq[3]), expFlag(seq[3], 2'd1));
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    testReset();
    testPerfect();
    testSingleMiss();
    testDoubleMiss();
    testSaturation();
    testToleranceSweep();
    testBackToBack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule